// File: doc/BRIEF.md
# Snoop Broadcast Engine with Active-Agent Mask

This block accepts one maintenance request at a time on a valid/ready stream and fans it out as a snoop to every agent whose bit in a software-writable participation mask is set. It then waits for one response from each snooped agent and raises a completion on a second valid/ready stream. An agent that software has cleared in the mask, for example because it has been powered down, receives no snoop and is not counted among the responses awaited.

The mask lives in a bank of 64-bit registers. There is one register for each group of 64 agent IDs, and an agent's bit index is its ID. The snoop set and the wait set are taken from the mask when a request is accepted, so software may change the mask at any time without disturbing a request that is in flight. A response that does not belong to the current wait set is dropped and sets a sticky error flag.

Back-pressure rules. A request transfers on a cycle where `req_valid` and `req_ready` are both high. Each agent's snoop transfers on a cycle where its `snp_valid` and `snp_ready` bits are both high. The completion transfers when `done_valid` and `done_ready` are both high. A valid, once raised, stays high with a stable payload until its transfer. Responses are single-cycle pulses and cannot be back-pressured.

Top module: `snoop_bcast_top`

## Requirements
- R1: `N_AGENTS` (1 to 256) sets the agent count. The mask bank holds ceil(N_AGENTS/64) registers. Register address k holds agents 64k to 64k+63, and each agent sits at bit (ID mod 64), so agent 68 is bit 4 at address 1.
- R2: After reset, every mask bit for an agent below `N_AGENTS` is 1.
- R3: Mask bits at or above `N_AGENTS` read as 0 and ignore writes. Addresses at or above the register count read as all zeros.
- R4: A cycle with `csr_wr_en` high loads all 64 bits of the register at `csr_addr`, within the limits of R3. `csr_rdata` shows the register at `csr_addr` in the same cycle, without a clock edge.
- R5: `req_ready` is high only while no request is outstanding. While it is high, no snoop is valid.
- R6: In the cycle after a request is accepted, `snp_valid[i]` is 1 exactly for the agents whose mask bit was 1 at acceptance, and `snp_payload` equals the request payload. Each `snp_valid[i]` stays high until that agent's `snp_ready[i]`.
- R7: `done_valid` rises only after every agent snooped for the request has been sent its snoop and has returned a response. Agents that were masked off are not waited for.
- R8: A mask write while a request is outstanding does not change that request's snoop set or wait set.
- R9: If the mask is all zeros when a request is accepted, no snoop is issued and `done_valid` is high in the next cycle.
- R10: `done_valid` stays high, with `done_payload` equal to the request payload, until `done_ready`. The next request is accepted only after that handshake.
- R11: A response pulse counts only when the agent is in the current wait set and its snoop has already transferred. Any other response is ignored and sets `rsp_err`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Mask register write strobe |
| csr_addr | input | 2 | Mask register address |
| csr_wdata | input | 64 | Mask register write data |
| csr_rdata | output | 64 | Mask register read data (combinational) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_payload | input | PAYLOAD_W | Request payload |
| snp_valid | output | N_AGENTS | Per-agent snoop valid |
| snp_ready | input | N_AGENTS | Per-agent snoop ready |
| snp_payload | output | PAYLOAD_W | Snoop payload shared by all agents |
| rsp_valid | input | N_AGENTS | Per-agent response pulse |
| done_valid | output | 1 | Completion valid |
| done_ready | input | 1 | Completion ready |
| done_payload | output | PAYLOAD_W | Payload of the completed request |
| rsp_err | output | 1 | Sticky unexpected-response flag |

## Verification
The bench uses 70 agents, so the bank spans two registers and has a partly used top register and two unmapped addresses. Requests are sent under three mask patterns:
- A sparse mask with agents in both registers. This separates correct ID-to-bit mapping from a plain copy of the mask.
- An all-zero mask. This exposes a missing fast completion.
- A full mask answered in a single cycle. This catches trackers that lose simultaneous responses.

Snoop ready is held low, and a mask write is made mid-request, to show that snoops are held and the captured sets are frozen. An early response from a snooped agent shows that counting starts only after delivery and that the error flag is sticky.

// File: rtl/snb_pkg.sv
package snb_pkg;
  localparam int CSR_W      = 64;
  localparam int CSR_AW     = 2;
  localparam int MAX_AGENTS = 256;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } snb_state_e;

  // Number of 64-bit mask registers needed for a given agent count.
  function automatic int num_regs(input int n_agents);
    return (n_agents + CSR_W - 1) / CSR_W;
  endfunction
endpackage

// File: rtl/snb_mask_bank.sv
module snb_mask_bank #(
  parameter int N_AGENTS = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [snb_pkg::CSR_AW-1:0] addr,
  input  logic [snb_pkg::CSR_W-1:0]  wr_data,
  output logic [snb_pkg::CSR_W-1:0]  rd_data,
  output logic [N_AGENTS-1:0]        mask
);
  localparam int NREGS = snb_pkg::num_regs(N_AGENTS);
  localparam int PAD_W = NREGS * snb_pkg::CSR_W;

  logic [N_AGENTS-1:0] mask_q, mask_d;
  logic [PAD_W-1:0]    padded;
  logic                unused_wdata;

  assign unused_wdata = ^wr_data;

  // Each agent bit is written only from its own register word and lane.
  always_comb begin
    mask_d = mask_q;
    for (int a = 0; a < N_AGENTS; a++) begin
      if (wr_en && int'(addr) == a / snb_pkg::CSR_W)
        mask_d[a] = wr_data[a % snb_pkg::CSR_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= mask_d;
  end

  always_comb begin
    padded = '0;
    padded[N_AGENTS-1:0] = mask_q;
  end

  always_comb begin
    rd_data = '0;
    for (int r = 0; r < NREGS; r++) begin
      if (int'(addr) == r)
        rd_data = padded[r*snb_pkg::CSR_W +: snb_pkg::CSR_W];
    end
  end

  assign mask = mask_q;
endmodule

// File: rtl/snb_fanout.sv
module snb_fanout #(
  parameter int N_AGENTS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [N_AGENTS-1:0] cap_mask,
  input  logic [N_AGENTS-1:0] snp_ready,
  output logic [N_AGENTS-1:0] pend
);
  logic [N_AGENTS-1:0] pend_q;
  logic [N_AGENTS-1:0] sent;

  // Per-agent delivery: a pending snoop clears on its own handshake.
  for (genvar a = 0; a < N_AGENTS; a++) begin : g_lane
    assign sent[a] = pend_q[a] & snp_ready[a];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pend_q <= '0;
    else if (start) pend_q <= cap_mask;
    else            pend_q <= pend_q & ~sent;
  end

  assign pend = pend_q;
endmodule

// File: rtl/snb_rsp_tracker.sv
module snb_rsp_tracker #(
  parameter int N_AGENTS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [N_AGENTS-1:0] cap_mask,
  input  logic [N_AGENTS-1:0] pend,
  input  logic [N_AGENTS-1:0] rsp_valid,
  output logic [N_AGENTS-1:0] wait_set,
  output logic                err
);
  logic [N_AGENTS-1:0] wait_q;
  logic [N_AGENTS-1:0] hit, stray;
  logic                err_q;

  // A response counts only for an awaited agent whose snoop already left.
  for (genvar a = 0; a < N_AGENTS; a++) begin : g_agent
    assign hit[a]   = rsp_valid[a] & wait_q[a] & ~pend[a];
    assign stray[a] = rsp_valid[a] & ~hit[a];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     wait_q <= '0;
    else if (start) wait_q <= cap_mask;
    else            wait_q <= wait_q & ~hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (|stray)  err_q <= 1'b1;
  end

  assign wait_set = wait_q;
  assign err      = err_q;
endmodule

// File: rtl/snoop_bcast_top.sv
module snoop_bcast_top #(
  parameter int N_AGENTS  = 8,
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 csr_wr_en,
  input  logic [1:0]           csr_addr,
  input  logic [63:0]          csr_wdata,
  output logic [63:0]          csr_rdata,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PAYLOAD_W-1:0] req_payload,
  output logic [N_AGENTS-1:0]  snp_valid,
  input  logic [N_AGENTS-1:0]  snp_ready,
  output logic [PAYLOAD_W-1:0] snp_payload,
  input  logic [N_AGENTS-1:0]  rsp_valid,
  output logic                 done_valid,
  input  logic                 done_ready,
  output logic [PAYLOAD_W-1:0] done_payload,
  output logic                 rsp_err
);
  import snb_pkg::*;

  snb_state_e           state_q;
  logic [PAYLOAD_W-1:0] payload_q;
  logic [N_AGENTS-1:0]  act_mask;
  logic [N_AGENTS-1:0]  pend;
  logic [N_AGENTS-1:0]  wait_set;
  logic                 accept;
  logic                 retire;

  snb_mask_bank #(.N_AGENTS(N_AGENTS)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (csr_wr_en),
    .addr    (csr_addr),
    .wr_data (csr_wdata),
    .rd_data (csr_rdata),
    .mask    (act_mask)
  );

  snb_fanout #(.N_AGENTS(N_AGENTS)) u_fanout (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cap_mask  (act_mask),
    .snp_ready (snp_ready),
    .pend      (pend)
  );

  snb_rsp_tracker #(.N_AGENTS(N_AGENTS)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .cap_mask  (act_mask),
    .pend      (pend),
    .rsp_valid (rsp_valid),
    .wait_set  (wait_set),
    .err       (rsp_err)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid & req_ready;
  assign done_valid = (state_q == ST_ACTIVE) & ~(|pend) & ~(|wait_set);
  assign retire     = done_valid & done_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE:   if (accept) state_q <= ST_ACTIVE;
        ST_ACTIVE: if (retire) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      payload_q <= '0;
    else if (accept) payload_q <= req_payload;
  end

  assign snp_valid    = pend;
  assign snp_payload  = payload_q;
  assign done_payload = payload_q;
endmodule

// File: rtl/snb_checker.sv
module snb_checker #(
  parameter int N_AGENTS  = 8,
  parameter int PAYLOAD_W = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic                req_ready,
  input logic [N_AGENTS-1:0] act_mask,
  input logic [N_AGENTS-1:0] snp_valid,
  input logic [N_AGENTS-1:0] snp_ready,
  input logic                done_valid,
  input logic                done_ready,
  input logic                rsp_err,
  input logic [1:0]          csr_addr,
  input logic [63:0]         csr_rdata
);
  localparam int NREGS = snb_pkg::num_regs(N_AGENTS);

  a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(csr_addr) >= NREGS) |-> (csr_rdata == '0));

  a_r5_idle_no_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (snp_valid == '0));

  a_r6_snoop_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (snp_valid == $past(act_mask)));

  a_r6_snoop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|(snp_valid & ~snp_ready)) |=>
      ((snp_valid & $past(snp_valid & ~snp_ready)) == $past(snp_valid & ~snp_ready)));

  a_r7_done_after_snoops: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (snp_valid == '0));

  a_r9_empty_fast_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && act_mask == '0) |=> done_valid);

  a_r10_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> done_valid);

  a_r10_no_accept_while_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !req_ready);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |=> rsp_err);
endmodule

bind snoop_bcast_top snb_checker #(.N_AGENTS(N_AGENTS), .PAYLOAD_W(PAYLOAD_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .act_mask   (act_mask),
  .snp_valid  (snp_valid),
  .snp_ready  (snp_ready),
  .done_valid (done_valid),
  .done_ready (done_ready),
  .rsp_err    (rsp_err),
  .csr_addr   (csr_addr),
  .csr_rdata  (csr_rdata)
);

// File: tb/snoop_bcast_top_tb_top.sv
module snoop_bcast_top_tb_top;
  localparam int NA = 70;
  localparam int PW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_wr_en = 1'b0;
  logic [1:0]    csr_addr = '0;
  logic [63:0]   csr_wdata = '0;
  logic [63:0]   csr_rdata;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_payload = '0;
  logic [NA-1:0] snp_valid;
  logic [NA-1:0] snp_ready = '0;
  logic [PW-1:0] snp_payload;
  logic [NA-1:0] rsp_valid = '0;
  logic          done_valid;
  logic          done_ready = 1'b0;
  logic [PW-1:0] done_payload;
  logic          rsp_err;

  int checks = 0;
  int errors = 0;
  int popped = 0;
  bit finished = 0;
  logic [PW-1:0] exp_q[$];

  always #10 clk = ~clk;

  snoop_bcast_top #(.N_AGENTS(NA), .PAYLOAD_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .csr_wr_en(csr_wr_en), .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_payload(req_payload),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_payload(snp_payload),
    .rsp_valid(rsp_valid),
    .done_valid(done_valid), .done_ready(done_ready), .done_payload(done_payload),
    .rsp_err(rsp_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard monitor: pops one expected payload per completion handshake.
  always @(posedge clk) begin
    if (rst_n && done_valid && done_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected completion", 128'(done_payload), 128'h0);
      end else begin
        logic [PW-1:0] e;
        e = exp_q.pop_front();
        popped++;
        chk(done_payload == e, "R10 completion payload", 128'(done_payload), 128'(e));
      end
    end
  end

  task automatic csr_write(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic csr_check(input logic [1:0] a, input logic [63:0] e, input string tag);
    csr_addr = a;
    #1;
    chk(csr_rdata == e, tag, 128'(csr_rdata), 128'(e));
  endtask

  // Driver: pushes the expected completion and leaves on the negedge after acceptance.
  task automatic send_req(input logic [PW-1:0] p);
    @(negedge clk);
    chk(req_ready == 1'b1, "R5 ready before request", 128'(req_ready), 128'h1);
    req_valid = 1'b1; req_payload = p;
    exp_q.push_back(p);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_rsp(input logic [NA-1:0] v);
    @(negedge clk);
    rsp_valid = v;
    @(negedge clk);
    rsp_valid = '0;
  endtask

  task automatic finish_done();
    done_ready = 1'b1;
    @(negedge clk);
    done_ready = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic [NA-1:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // Reset state
    chk(req_ready == 1'b1, "R5 idle ready after reset", 128'(req_ready), 128'h1);
    chk(snp_valid == '0, "R5 no snoop after reset", 128'(snp_valid), 128'h0);
    chk(done_valid == 1'b0, "R10 no done after reset", 128'(done_valid), 128'h0);
    chk(rsp_err == 1'b0, "R11 err clear after reset", 128'(rsp_err), 128'h0);
    csr_check(2'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 reg0 all active");
    csr_check(2'd1, 64'h3F, "R1 R2 reg1 holds agents 64..69");
    csr_check(2'd2, 64'h0, "R3 unmapped addr 2 reads zero");
    csr_check(2'd3, 64'h0, "R3 unmapped addr 3 reads zero");

    // Register writes and unused bits
    csr_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_check(2'd1, 64'h3F, "R3 unused bits ignore writes");
    csr_write(2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_check(2'd2, 64'h0, "R3 write to unmapped addr");
    csr_write(2'd0, 64'h5);
    csr_write(2'd1, 64'h10);
    csr_check(2'd0, 64'h5, "R4 reg0 readback");
    csr_check(2'd1, 64'h10, "R4 reg1 readback");

    // Sparse request: agents 0, 2 and 68 (bit 4 of reg1)
    m = '0; m[0] = 1'b1; m[2] = 1'b1; m[68] = 1'b1;
    snp_ready = '0;
    send_req(16'h1234);
    chk(snp_valid == m, "R1 R6 sparse snoop set", 128'(snp_valid), 128'(m));
    chk(snp_payload == 16'h1234, "R6 snoop payload", 128'(snp_payload), 128'h1234);
    chk(req_ready == 1'b0, "R5 busy not ready", 128'(req_ready), 128'h0);
    csr_write(2'd0, 64'hFF);
    chk(snp_valid == m, "R6 R8 snoop held after mask write", 128'(snp_valid), 128'(m));
    // Early response from agent 0 before its snoop transfers
    pulse_rsp(70'h1);
    chk(rsp_err == 1'b1, "R11 early response flagged", 128'(rsp_err), 128'h1);
    chk(snp_valid == m, "R6 still held", 128'(snp_valid), 128'(m));
    snp_ready = '1;
    @(negedge clk);
    chk(snp_valid == '0, "R6 snoops delivered", 128'(snp_valid), 128'h0);
    chk(done_valid == 1'b0, "R11 early response not counted", 128'(done_valid), 128'h0);
    m = '0; m[0] = 1'b1; m[2] = 1'b1;
    pulse_rsp(m);
    chk(done_valid == 1'b0, "R7 waiting for agent 68", 128'(done_valid), 128'h0);
    m = '0; m[68] = 1'b1;
    pulse_rsp(m);
    chk(done_valid == 1'b1, "R7 R8 done after captured set", 128'(done_valid), 128'h1);
    @(negedge clk);
    chk(done_valid == 1'b1, "R10 done held", 128'(done_valid), 128'h1);
    chk(req_ready == 1'b0, "R10 no accept before handshake", 128'(req_ready), 128'h0);
    finish_done();
    chk(done_valid == 1'b0, "R10 done drops after handshake", 128'(done_valid), 128'h0);
    chk(req_ready == 1'b1, "R10 ready after handshake", 128'(req_ready), 128'h1);
    chk(rsp_err == 1'b1, "R11 err sticky", 128'(rsp_err), 128'h1);

    // Empty mask request
    csr_write(2'd0, 64'h0);
    csr_write(2'd1, 64'h0);
    send_req(16'hA5A5);
    chk(done_valid == 1'b1, "R9 done one cycle after accept", 128'(done_valid), 128'h1);
    chk(snp_valid == '0, "R9 no snoops", 128'(snp_valid), 128'h0);
    finish_done();

    // Full mask, all responses in one cycle
    csr_write(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_write(2'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    csr_check(2'd1, 64'h3F, "R3 reg1 full write trimmed");
    send_req(16'hBEEF);
    chk(snp_valid == {NA{1'b1}}, "R6 full snoop set", 128'(snp_valid), 128'({NA{1'b1}}));
    @(negedge clk);
    chk(snp_valid == '0, "R6 full set delivered", 128'(snp_valid), 128'h0);
    pulse_rsp({NA{1'b1}});
    chk(done_valid == 1'b1, "R7 simultaneous responses", 128'(done_valid), 128'h1);
    finish_done();

    chk(popped == 3, "R10 completions seen", 128'(popped), 128'd3);
    chk(exp_q.size() == 0, "R10 scoreboard drained", 128'(exp_q.size()), 128'h0);
    finish_run();
  end
endmodule